// File: doc/BRIEF.md
# Sub-Word Lane Memory Port

This block is a memory port in front of a small array of 64-bit rows. Each request carries a byte address, a size code, a write flag, a byte-reverse flag and write data. The address is split into a row number (the upper bits) and a byte offset inside the row (the low three bits). A load reads the addressed lane of 1, 2, 4 or 8 bytes and returns it right-aligned and zero-extended. A store replaces only the addressed lane and keeps every other byte of the row.

The block can reverse the byte order of the data inside the access width, chosen per request. On a load the reversal is applied after the lane is extracted. On a store it is applied before the lane is merged into the row. A request whose offset is not a multiple of its size is rejected with an error flag and leaves storage unchanged. The port accepts one request every cycle and answers exactly one cycle later.

Top module: `lane_mem_port`

## Requirements
- R1: After reset, every row reads as zero and `rsp_valid` is low.
- R2: Byte address bits [2:0] select the byte offset inside a row and the remaining upper bits select the row. Rows are independent, so a store to one row never alters another.
- R3: The size code maps 0 to 1 byte, 1 to 2 bytes, 2 to 4 bytes and 3 to 8 bytes. A request whose offset is not a multiple of its byte count returns `rsp_err`=1 with `rsp_rdata`=0 and does not modify storage. An aligned request returns `rsp_err`=0.
- R4: An aligned load returns the addressed bytes right-aligned, with offset byte k in the row at result bits [8k+7:8k]. All result bits above the access width are zero.
- R5: An aligned store writes the low bytes of `req_wdata` into the addressed lane. All other bytes of the row keep their value, and write-data bits above the access width are ignored.
- R6: A load with `req_swap`=1 returns the extracted lane with its byte order reversed inside the access width: result byte i equals lane byte (n-1-i), where n is the byte count.
- R7: A store with `req_swap`=1 writes write-data byte (n-1-i) into lane byte i.
- R8: `req_ready` is always high. Each accepted request produces `rsp_valid` high for exactly the following cycle, and `rsp_valid` is low otherwise. Store responses carry `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | ADDR_W (8) | Byte address |
| req_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_write | input | 1 | 1 = store, 0 = load |
| req_swap | input | 1 | Reverse byte order inside the access width |
| req_wdata | input | 64 | Store data, right-aligned |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_rdata | output | 64 | Load data, right-aligned and zero-extended |
| rsp_err | output | 1 | Misaligned request was rejected |

## Verification
A wrong lane mask or shift in the merge path corrupts neighbouring bytes of the row. The damage stays invisible until the next full-row load of that row, so the bench follows every narrow store with a lane read-back and a whole-row read-back within a few cycles. A missed misalignment check shows up as an unexpected change in the whole-row read that follows the rejected store. A wrong reversal index shows up as permuted bytes in the very next response.

// File: rtl/lmp_pkg.sv
package lmp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_ROW  = 2'd3
    } lmp_size_e;

    // number of bytes for a size code
    function automatic int size_bytes(input logic [1:0] sz);
        return 1 << sz;
    endfunction

endpackage

// File: rtl/lmp_lane_align.sv
// Lane placement: which bytes of the row an access covers and whether it is aligned.
module lmp_lane_align #(
    parameter int ROW_BYTES = 8,
    localparam int OFS_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = ROW_BYTES * 8
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [1:0]       size,
    output logic             misalign,
    output logic [ROW_W-1:0] lane_mask
);
    import lmp_pkg::*;

    logic [ROW_BYTES-1:0] byte_en;

    always_comb begin
        int nb;
        int o;
        nb       = size_bytes(size);
        o        = int'(ofs);
        misalign = (o & (nb - 1)) != 0;
        for (int b = 0; b < ROW_BYTES; b++) begin
            byte_en[b] = (b >= o) && (b < o + nb);
        end
    end

    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_mask
        assign lane_mask[g*8 +: 8] = {8{byte_en[g]}};
    end

endmodule

// File: rtl/lmp_byte_swap.sv
// Truncates data to the access width and optionally reverses its byte order.
module lmp_byte_swap #(
    parameter int ROW_BYTES = 8,
    localparam int NSZ      = $clog2(ROW_BYTES) + 1,
    localparam int ROW_W    = ROW_BYTES * 8
) (
    input  logic [ROW_W-1:0] din,
    input  logic [1:0]       size,
    input  logic             en,
    output logic [ROW_W-1:0] dout
);
    logic [ROW_W-1:0] rev [NSZ];
    logic [ROW_W-1:0] cut [NSZ];

    for (genvar s = 0; s < NSZ; s++) begin : g_size
        localparam int NB = 1 << s;
        for (genvar i = 0; i < ROW_BYTES; i++) begin : g_byte
            if (i < NB) begin : g_in
                assign rev[s][i*8 +: 8] = din[(NB-1-i)*8 +: 8];
                assign cut[s][i*8 +: 8] = din[i*8 +: 8];
            end else begin : g_out
                assign rev[s][i*8 +: 8] = 8'h00;
                assign cut[s][i*8 +: 8] = 8'h00;
            end
        end
    end

    assign dout = en ? rev[size] : cut[size];

endmodule

// File: rtl/lane_mem_port.sv
module lane_mem_port #(
    parameter int ADDR_W    = 8,
    parameter int ROW_BYTES = 8,
    localparam int OFS_W    = $clog2(ROW_BYTES),
    localparam int ROW_W    = ROW_BYTES * 8,
    localparam int IDX_W    = ADDR_W - OFS_W,
    localparam int ROWS     = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              req_swap,
    input  logic [ROW_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [ROW_W-1:0]  rsp_rdata,
    output logic              rsp_err
);
    typedef struct packed {
        logic             vld;
        logic             err;
        logic [ROW_W-1:0] data;
    } rsp_t;

    rsp_t             rsp_d, rsp_q;
    logic [ROW_W-1:0] mem_d [ROWS];
    logic [ROW_W-1:0] mem_q [ROWS];

    logic [IDX_W-1:0] row_idx;
    logic [OFS_W-1:0] byte_ofs;
    logic [OFS_W+2:0] bit_sh;
    logic             misalign;
    logic [ROW_W-1:0] lane_mask;
    logic [ROW_W-1:0] cur_row;
    logic [ROW_W-1:0] lane_raw;
    logic [ROW_W-1:0] load_val;
    logic [ROW_W-1:0] store_val;

    assign row_idx  = req_addr[ADDR_W-1:OFS_W];
    assign byte_ofs = req_addr[OFS_W-1:0];
    assign bit_sh   = {byte_ofs, 3'b000};
    assign cur_row  = mem_q[row_idx];
    assign lane_raw = (cur_row & lane_mask) >> bit_sh;

    lmp_lane_align #(.ROW_BYTES(ROW_BYTES)) u_align (
        .ofs      (byte_ofs),
        .size     (req_size),
        .misalign (misalign),
        .lane_mask(lane_mask)
    );

    // load path: extract, then reverse
    lmp_byte_swap #(.ROW_BYTES(ROW_BYTES)) u_swap_ld (
        .din (lane_raw),
        .size(req_size),
        .en  (req_swap),
        .dout(load_val)
    );

    // store path: reverse, then merge
    lmp_byte_swap #(.ROW_BYTES(ROW_BYTES)) u_swap_st (
        .din (req_wdata),
        .size(req_size),
        .en  (req_swap),
        .dout(store_val)
    );

    always_comb begin
        rsp_d = '0;
        for (int r = 0; r < ROWS; r++) begin
            mem_d[r] = mem_q[r];
        end
        if (req_valid) begin
            rsp_d.vld = 1'b1;
            if (misalign) begin
                rsp_d.err = 1'b1;
            end else if (req_write) begin
                mem_d[row_idx] = (cur_row & ~lane_mask) | (store_val << bit_sh);
            end else begin
                rsp_d.data = load_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= '0;
            end
        end else begin
            rsp_q <= rsp_d;
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= mem_d[r];
            end
        end
    end

    assign req_ready = 1'b1;
    assign rsp_valid = rsp_q.vld;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.data;

endmodule

// File: rtl/lmp_checker.sv
module lmp_checker #(
    parameter int ADDR_W    = 8,
    parameter int ROW_BYTES = 8,
    localparam int ROW_W    = ROW_BYTES * 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              req_write,
    input logic              rsp_valid,
    input logic [ROW_W-1:0]  rsp_rdata,
    input logic              rsp_err
);
    logic misal;
    assign misal = (int'(req_addr[2:0]) & ((1 << req_size) - 1)) != 0;

    p_rsp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_store_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

    p_misalign_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misal) |=> rsp_err);

    p_aligned_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !misal) |=> !rsp_err);

    p_err_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    p_byte_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd0) |=> (rsp_rdata[ROW_W-1:8] == '0));

endmodule

bind lane_mem_port lmp_checker #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_lmp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_size (req_size),
    .req_write(req_write),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err)
);

// File: tb/lane_mem_port_bench.sv
module lane_mem_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        req_swap = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        rsp_err;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0]  mdl [256];
    logic [63:0] seed = 64'h1234_5678_9abc_def0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_mem_port u_lane_mem_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
        .req_swap(req_swap), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [7:0] a, input logic [1:0] sz, input logic sw,
                        input logic [63:0] wd, output logic [63:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        req_swap = sw; req_wdata = wd;
        chk(req_ready == 1'b1, "R8 ready", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        rd = rsp_rdata; er = rsp_err;
        chk(rsp_valid == 1'b1, "R8 response valid", {63'd0, rsp_valid}, 64'd1);
    endtask

    function automatic logic [63:0] exp_load(input logic [7:0] a, input int nb, input bit sw);
        logic [63:0] v = '0;
        for (int i = 0; i < nb; i++) begin
            if (sw) v[i*8 +: 8] = mdl[8'(int'(a) + nb - 1 - i)];
            else    v[i*8 +: 8] = mdl[8'(int'(a) + i)];
        end
        return v;
    endfunction

    function automatic logic [63:0] nxt(input logic [63:0] s);
        return s * 64'd6364136223846793005 + 64'd1442695040888963407;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd, exp;
        logic er;
        for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 valid low in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 idle after reset", {63'd0, rsp_valid}, 64'd0);
        // R1: rows read zero after reset
        for (int r = 0; r < 32; r += 7) begin
            xfer(1'b0, 8'(r * 8), 2'd3, 1'b0, '0, rd, er);
            chk(rd == 64'd0 && !er, "R1 row zero after reset", rd, 64'd0);
        end
        // sweep sizes, offsets, swap flag and three rows
        for (int sz = 0; sz < 4; sz++) begin
            for (int off = 0; off < 8; off++) begin
                for (int sw = 0; sw < 2; sw++) begin
                    for (int ri = 0; ri < 3; ri++) begin
                        int row, nb;
                        bit mis;
                        logic [7:0] a;
                        logic [63:0] wd;
                        row = (ri == 0) ? 0 : (ri == 1) ? 13 : 31;
                        nb  = 1 << sz;
                        mis = (off % nb) != 0;
                        a   = 8'(row * 8 + off);
                        seed = nxt(seed);
                        wd = seed;
                        xfer(1'b1, a, 2'(sz), 1'(sw), wd, rd, er);
                        chk(er == mis, mis ? "R3 store misalign flag" : "R3 store aligned no error",
                            {63'd0, er}, {63'd0, mis});
                        chk(rd == 64'd0, "R8 store response data zero", rd, 64'd0);
                        if (!mis) begin
                            for (int i = 0; i < nb; i++) begin
                                if (sw) mdl[8'(int'(a) + i)] = wd[(nb-1-i)*8 +: 8];
                                else    mdl[8'(int'(a) + i)] = wd[i*8 +: 8];
                            end
                        end
                        // lane read-back with the same swap setting
                        xfer(1'b0, a, 2'(sz), 1'(sw), '0, rd, er);
                        exp = mis ? 64'd0 : exp_load(a, nb, 1'(sw));
                        chk(rd == exp && er == mis, sw ? "R6 swapped lane load" : "R4 lane load", rd, exp);
                        // whole-row read-back: preservation, placement and untouched storage
                        xfer(1'b0, 8'(row * 8), 2'd3, 1'b0, '0, rd, er);
                        exp = exp_load(8'(row * 8), 8, 1'b0);
                        chk(rd == exp && !er,
                            mis ? "R3 rejected store left row" : (sw ? "R7 swapped store placement" : "R5 merge preserves row"),
                            rd, exp);
                    end
                end
            end
        end
        // R2: every row independent and matching the model
        for (int r = 0; r < 32; r++) begin
            xfer(1'b0, 8'(r * 8), 2'd3, 1'b0, '0, rd, er);
            exp = exp_load(8'(r * 8), 8, 1'b0);
            chk(rd == exp, "R2 row isolation", rd, exp);
        end
        // R8: no response without a request
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 single-cycle response", {63'd0, rsp_valid}, 64'd0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule